// File: doc/BRIEF.md
# Ethernet Controller Interrupt Status and Summary Unit

This block keeps the interrupt cause word and the interrupt enable mask of an Ethernet controller. The transmit, receive, link and bus logic raise causes with one-cycle pulses on a set vector. Software reads both words through a small register port. It acknowledges causes by writing ones to the status word, and it programs the enable mask by writing the enable word.

Two summary flags group the enabled causes into a "normal" class and an "abnormal" class. The flags are rebuilt from status AND enable on every update. A single level interrupt line is raised when an enabled summary flag is set. The transmit and receive process-state codes are supplied by the engines that own them. They appear in the status word without being stored or cleared here.

Top module: `nic_irq_summary`

## Requirements
- R1: After reset the status word reads 0xF0000000 (with both state inputs at 0), the enable word reads 0xF3FE0000, and `irq` is 0.
- R2: A 1 on `cause_set` at a cause position sets that status bit at the next clock edge, and the bit stays set until software clears it. The cause positions are 0–12, 14, 26 and 27. A 1 at any other position has no effect on the status word.
- R3: A write with `reg_sel`=0 clears each cause bit whose `reg_wdata` bit is 1 and leaves every other cause bit unchanged. Bits 31:28 keep reading 1 after any write.
- R4: When a set pulse and a write-one clear hit the same cause bit in the same cycle, the bit ends up set.
- R5: Status bit 16 (normal summary) is 1 exactly when some cause in {0, 2, 6, 11, 14} is set in both status and enable.
- R6: Status bit 15 (abnormal summary) is 1 exactly when some cause in {1, 3, 4, 5, 7, 8, 9, 10, 12, 26, 27} is set in both status and enable.
- R7: The summary bits are rebuilt after every update. A write-one to bit 16 or bit 15 while an enabled cause of its class is still set leaves that summary bit at 1.
- R8: A write with `reg_sel`=1 stores all 32 bits of `reg_wdata` as the enable word. The new value is readable from the next cycle.
- R9: `irq` is a register equal to (bit16 AND enable16) OR (bit15 AND enable15). It changes at the same clock edge that updates the status or enable word.
- R10: Status bits 19:17 show `rx_state` and bits 22:20 show `tx_state` in the same cycle. Bits 13 and 25:23 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cause_set | input | 32 | One-cycle set pulses, one per status bit position |
| rx_state | input | 3 | Receive process state code, shown in the status word |
| tx_state | input | 3 | Transmit process state code, shown in the status word |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The checker reads the status word only in cycles where `reg_sel` is 0. It takes the write-data and set vectors from the previous cycle as what the design saw at that edge. It therefore assumes the inputs are steady around each rising edge and that `cause_set` is 0 while reset is held. The bench changes inputs one time unit after the edge and holds `cause_set` at 0 during reset. It keeps `reg_sel` at 0 in its read-back phases. Random set vectors are made sparse by ANDing several draws. This lets causes pile up and then get cleared, rather than saturating the word.

// File: rtl/nic_irq_summary.sv
module nic_irq_summary #(
  parameter int DW       = 32,
  parameter int ST_W     = 3,
  parameter int RXST_LSB = 17,
  parameter int TXST_LSB = 20,
  parameter int B_TXDONE = 0,
  parameter int B_TXSTOP = 1,
  parameter int B_TXNBUF = 2,
  parameter int B_JABBER = 3,
  parameter int B_LNKOK  = 4,
  parameter int B_UNDER  = 5,
  parameter int B_RXDONE = 6,
  parameter int B_RXNBUF = 7,
  parameter int B_RXSTOP = 8,
  parameter int B_RXWDOG = 9,
  parameter int B_ERLYTX = 10,
  parameter int B_TIMER  = 11,
  parameter int B_LNKBAD = 12,
  parameter int B_ERLYRX = 14,
  parameter int B_ABN    = 15,
  parameter int B_NRM    = 16,
  parameter int B_GPIO   = 26,
  parameter int B_LNKCHG = 27,
  parameter logic [DW-1:0] STAT_RST = 32'hF000_0000,
  parameter logic [DW-1:0] EN_RST   = 32'hF3FE_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   cause_set,
  input  logic [ST_W-1:0] rx_state,
  input  logic [ST_W-1:0] tx_state,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq
);

  localparam logic [DW-1:0] ONE = 1;
  localparam logic [DW-1:0] NRM_MASK =
    (ONE << B_TXDONE) | (ONE << B_TXNBUF) | (ONE << B_RXDONE) |
    (ONE << B_TIMER)  | (ONE << B_ERLYRX);
  localparam logic [DW-1:0] ABN_MASK =
    (ONE << B_TXSTOP) | (ONE << B_JABBER) | (ONE << B_LNKOK)  |
    (ONE << B_UNDER)  | (ONE << B_RXNBUF) | (ONE << B_RXSTOP) |
    (ONE << B_RXWDOG) | (ONE << B_ERLYTX) | (ONE << B_LNKBAD) |
    (ONE << B_GPIO)   | (ONE << B_LNKCHG);
  localparam logic [DW-1:0] CAUSE_MASK = NRM_MASK | ABN_MASK;
  localparam logic [DW-1:0] ST_ONES    = (ONE << ST_W) - ONE;
  localparam logic [DW-1:0] FIELD_MASK =
    CAUSE_MASK | (ONE << B_NRM) | (ONE << B_ABN) |
    (ST_ONES << RXST_LSB) | (ST_ONES << TXST_LSB);
  localparam logic [DW-1:0] FIXED_BITS = STAT_RST & ~FIELD_MASK;
  localparam logic NRM_RST = |(STAT_RST & EN_RST & NRM_MASK);
  localparam logic ABN_RST = |(STAT_RST & EN_RST & ABN_MASK);

  logic [DW-1:0] cause_q, en_q;
  logic          nrm_q, abn_q, irq_q;

  wire [DW-1:0] clr_vec = (reg_wr && !reg_sel) ? reg_wdata : '0;
  wire [DW-1:0] cause_d = ((cause_q & ~clr_vec) | cause_set) & CAUSE_MASK;
  wire [DW-1:0] en_d    = (reg_wr && reg_sel) ? reg_wdata : en_q;
  wire [DW-1:0] live_d  = cause_d & en_d;
  wire          nrm_d   = |(live_d & NRM_MASK);
  wire          abn_d   = |(live_d & ABN_MASK);
  wire          irq_d   = (nrm_d & en_d[B_NRM]) | (abn_d & en_d[B_ABN]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= STAT_RST & CAUSE_MASK;
      en_q    <= EN_RST;
      nrm_q   <= NRM_RST;
      abn_q   <= ABN_RST;
      irq_q   <= (NRM_RST & EN_RST[B_NRM]) | (ABN_RST & EN_RST[B_ABN]);
    end else begin
      cause_q <= cause_d;
      en_q    <= en_d;
      nrm_q   <= nrm_d;
      abn_q   <= abn_d;
      irq_q   <= irq_d;
    end
  end

  wire [DW-1:0] status_word =
    FIXED_BITS | cause_q |
    (DW'(nrm_q) << B_NRM) | (DW'(abn_q) << B_ABN) |
    (DW'(rx_state) << RXST_LSB) | (DW'(tx_state) << TXST_LSB);

  assign reg_rdata = reg_sel ? en_q : status_word;
  assign irq       = irq_q;

endmodule

// File: rtl/nic_irq_summary_chk.sv
module nic_irq_summary_chk #(
  parameter int DW = 32,
  parameter int ST_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [DW-1:0]   cause_set,
  input logic [ST_W-1:0] rx_state,
  input logic [ST_W-1:0] tx_state,
  input logic            reg_wr,
  input logic            reg_sel,
  input logic [DW-1:0]   reg_wdata,
  input logic [DW-1:0]   reg_rdata,
  input logic            irq
);
  localparam logic [DW-1:0] CAUSES = 32'h0C00_5FFF;
  localparam logic [DW-1:0] NRM    = 32'h0000_4845;
  localparam logic [DW-1:0] UNUSED = 32'h0380_2000;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_sel && $past(rst_n)) |-> ((reg_rdata & $past(cause_set) & CAUSES) == ($past(cause_set) & CAUSES))); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_sel && $past(rst_n && reg_wr && !reg_sel)) |-> ((reg_rdata & $past(reg_wdata & ~cause_set) & CAUSES) == '0)); // R3
  AST_ENABLE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && $past(rst_n && reg_wr && reg_sel)) |-> (reg_rdata == $past(reg_wdata))); // R8
  AST_STATE_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata[19:17] == rx_state && reg_rdata[22:20] == tx_state)); // R10
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> ((reg_rdata & UNUSED) == '0)); // R10
  AST_FIXED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata[31:28] == 4'hF)); // R3
  AST_IRQ_HAS_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_sel && irq) |-> (reg_rdata[16] || reg_rdata[15])); // R9
  AST_NRM_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_sel && reg_rdata[16]) |-> ((reg_rdata & NRM) != '0)); // R5
endmodule

bind nic_irq_summary nic_irq_summary_chk #(.DW(DW), .ST_W(ST_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cause_set(cause_set), .rx_state(rx_state),
  .tx_state(tx_state), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
);

// File: tb/nic_irq_summary_tb.sv
module nic_irq_summary_tb_top;
  localparam int CLK_P = 10;
  localparam logic [31:0] CAUSES = 32'h0C00_5FFF;
  localparam logic [31:0] NRM    = 32'h0000_4845;
  localparam logic [31:0] ABN    = 32'h0C00_17BA;

  logic clk = 0, rst_n = 0, reg_wr = 0, reg_sel = 0, irq;
  logic [31:0] cause_set = 0, reg_wdata = 0, reg_rdata;
  logic [2:0] rx_state = 0, tx_state = 0;
  int total = 0, bad = 0;
  logic [31:0] m_cause = 0, m_en = 32'hF3FE_0000;

  always #(CLK_P/2) clk = ~clk;

  nic_irq_summary dut_i (.clk(clk), .rst_n(rst_n), .cause_set(cause_set),
    .rx_state(rx_state), .tx_state(tx_state), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  function automatic logic [31:0] exp_status();
    logic n = |(m_cause & m_en & NRM);
    logic a = |(m_cause & m_en & ABN);
    return 32'hF000_0000 | m_cause | (32'(n) << 16) | (32'(a) << 15) |
           (32'(rx_state) << 17) | (32'(tx_state) << 20);
  endfunction

  function automatic logic exp_irq();
    logic [31:0] s = exp_status();
    return (s[16] & m_en[16]) | (s[15] & m_en[15]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic verify(input string tag);
    reg_wr = 0; cause_set = 0; reg_sel = 0;
    #1 chk({tag, " status"}, reg_rdata, exp_status());
    reg_sel = 1;
    #1 chk({tag, " enable"}, reg_rdata, m_en);
    chk({tag, " irq"}, {31'b0, irq}, {31'b0, exp_irq()});
    reg_sel = 0;
  endtask

  task automatic step(input logic [31:0] s, input logic wr, input logic sel,
                      input logic [31:0] wd, input string tag);
    cause_set = s; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    @(posedge clk);
    if (wr && !sel) m_cause = m_cause & ~wd;
    m_cause = (m_cause | s) & CAUSES;
    if (wr && sel) m_en = wd;
    #1 verify(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    verify("R1 reset");
    step(32'h1, 0, 0, 0, "R2 set TI while masked");
    step(32'h2000_2000, 0, 0, 0, "R2 non-cause set ignored");
    step(0, 1, 1, 32'h0001_0001, "R5 R9 normal enabled irq");
    step(0, 1, 0, 32'h0001_0000, "R7 summary w1c with live cause");
    step(32'h1, 1, 0, 32'h1, "R4 set beats clear");
    step(0, 1, 0, 32'h1, "R3 clear cause drops summary");
    step(32'h80, 1, 1, 32'h0000_0080, "R6 abnormal without summary enable");
    step(0, 1, 1, 32'h0000_8080, "R6 R9 abnormal summary enabled");
    step(32'h0C00_0000, 0, 0, 0, "R2 link and gpio causes");
    rx_state = 3'd5; tx_state = 3'd6;
    step(0, 1, 0, 32'hFFFF_FFFF, "R3 R10 clear all keeps fixed and state");
    step(0, 1, 1, 32'hFFFF_FFFF, "R8 enable all");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] s  = $urandom & $urandom & $urandom;
      logic [31:0] wd = ($urandom % 3 == 0) ? $urandom : ($urandom & $urandom);
      logic wr = ($urandom % 3) == 0;
      logic sel = ($urandom % 4) == 0;
      rx_state = 3'($urandom); tx_state = 3'($urandom);
      step(s, wr, sel, wd, "R2 R3 R4 R5 R6 R8 R9 R10 random");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule